// File: doc/BRIEF.md
# I2C Slave Address Matcher and Byte Receiver

This block is the receive half of an I2C target. It watches an oversampled SCL/SDA pair, detects bus Start and Stop conditions, shifts in bytes MSB first, compares address bytes against a host-programmed address under a host-programmed don't-care mask, and acknowledges by pulling SDA low. Accepted bytes are copied into a one-entry receive buffer guarded by a buffer-full flag and a sticky overflow flag. An interrupt flag reports every completed byte that concerned this target, and optionally also every Start and Stop.

For 10-bit addressing the match is done in two steps through the same single address register. After the header byte the block raises an update-address flag and holds SCL low. The host then loads the low address byte, which releases the clock. After the low byte the block stalls again until the host restores the header byte. A later Repeated Start with a read header is recognised for as long as the full 10-bit match still stands.

Top module: `i2c_slave_rx`

## Requirements
- R1: A Start (SDA falls while SCL is high) begins address reception. Bits are sampled on SCL rising edges, MSB first. A Stop (SDA rises while SCL is high) returns the block to idle with SDA and SCL released. After reset every status bit and output is 0.
- R2: In 7-bit mode (CTRL bit1 = 0) bits 7:1 of the first byte are compared with ADDR bits 7:1, and any bit whose MASK bit is 1 is ignored. On a match with buffer-full and overflow clear, SDA is pulled low from the 8th SCL fall to the 9th SCL fall, the byte goes to RXDATA and buffer-full (STATUS bit0) is set. A mismatch gives no ACK and leaves every flag untouched for the rest of that transfer.
- R3: The interrupt flag (STATUS bit3, also driven on irq_o) is set at the 9th SCL fall of every byte addressed to this target, whether it was acknowledged or suppressed. Writing 1 to STATUS bit3 clears it.
- R4: If buffer-full or overflow is set when a byte completes, no ACK is driven and RXDATA is kept. Overflow (STATUS bit1) is set if buffer-full was set.
- R5: Reading RXDATA (register 0) clears buffer-full. Overflow is cleared only by writing 1 to STATUS bit1.
- R6: A RXDATA read in the same clock as a byte completes counts as done first. The read returns the previous byte, and the new byte is acknowledged, loaded and leaves buffer-full set.
- R7: In 10-bit mode a first byte of the form 11110 A9 A8 0 (bits 2:1 compared with ADDR bits 2:1 under MASK) is acknowledged and loaded. At its 9th SCL fall update-address (STATUS bit2) is set and SCL is held low. A host write to ADDR (register 1) clears update-address and releases SCL.
- R8: The second 10-bit byte is compared in all 8 bits with ADDR under MASK. A match is acknowledged, loaded, and sets update-address with SCL held until the next ADDR write. The bytes after it are received as in R2 and R4.
- R9: After a full 10-bit match, a Repeated Start followed by the header with bit0 = 1 is acknowledged and sets buffer-full and the interrupt flag, but leaves update-address clear. The same read header without a prior full match in the transfer gets no ACK.
- R10: With CTRL bit2 = 1, each Start and each Stop also sets the interrupt flag.
- R11: With CTRL bit0 = 0 the block ignores the bus: no ACK, no clock hold, no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK) |
| irq_o | output | 1 | Interrupt flag level |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Register select: 0 RXDATA, 1 ADDR, 2 MASK, 3 CTRL, 4 STATUS |
| reg_wdata | input | DW | Host write data |
| reg_rdata | output | DW | Host read data, registered one clock after reg_rd |

## Verification
The host clearing buffer-full by reading RXDATA and the bus finishing a byte can fall in the same clock. Whether the byte is then acknowledged depends on which of the two is taken first. The bench provokes this by timing a RXDATA read to the exact cycle in which the synchronised 8th SCL fall reaches the decision logic. It judges the outcome against R6: the read must return the previous byte, the master must see an ACK, and a later read must return the new byte. The interrupt set and the host W1C clear can also coincide, and the logic resolves that in favour of the set.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam int RA_W = 3;
  localparam logic [RA_W-1:0] RA_RXDATA = 3'd0;
  localparam logic [RA_W-1:0] RA_ADDR   = 3'd1;
  localparam logic [RA_W-1:0] RA_MASK   = 3'd2;
  localparam logic [RA_W-1:0] RA_CTRL   = 3'd3;
  localparam logic [RA_W-1:0] RA_STAT   = 3'd4;

  localparam int CT_EN  = 0;
  localparam int CT_TEN = 1;
  localparam int CT_SE  = 2;

  localparam int ST_BF  = 0;
  localparam int ST_OV  = 1;
  localparam int ST_UPD = 2;
  localparam int ST_IRQ = 3;
  localparam int ST_RW  = 4;

  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_s, scl_q, sda_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_bit_shift.sv
module i2c_bit_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  output logic [DW-1:0] shreg,
  output logic          byte_done,
  output logic          ack_end
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);
  localparam logic [CW-1:0] ACK_BIT  = CW'(DW + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      shreg <= '0;
    end else begin
      if (scl_rise) begin
        if (cnt < LAST_BIT) shreg <= {shreg[DW-2:0], sda_s};
        if (cnt <= LAST_BIT) cnt <= cnt + 1'b1;
      end else if (scl_fall && cnt == ACK_BIT) begin
        cnt <= '0;
      end
    end
  end

  assign byte_done = scl_fall && (cnt == LAST_BIT);
  assign ack_end   = scl_fall && (cnt == ACK_BIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= ACK_BIT);  // R1
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] ref_addr,
  input  logic [DW-1:0] dont_care,
  input  logic          use_lsb,
  output logic          hit
);
  logic [DW-1:0] bit_ok;

  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign bit_ok[i] = ~use_lsb | dont_care[i] | (val[i] == ref_addr[i]);
      end else begin : g_upper
        assign bit_ok[i] = dont_care[i] | (val[i] == ref_addr[i]);
      end
    end
  endgenerate

  assign hit = &bit_ok;
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_slv_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          irq_o,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int HDR_W = 5;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [DW-1:0] shreg;
  logic byte_done, ack_end;
  logic hit_hi, hit_full;

  logic [DW-1:0] addr_r, mask_r, rxbuf_r;
  logic en_r, ten_r, se_r;
  logic bf_r, ov_r, upd_r, irq_r, rw_r;
  logic ack_r, ev_pend, upd_pend, matched10;
  phase_t phase;

  logic host_rd_buf, bf_eff, is_free;
  logic take, want_upd, set_m10;
  phase_t nxt_phase;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_bit_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .clear(start_det | stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .shreg(shreg), .byte_done(byte_done), .ack_end(ack_end)
  );

  i2c_addr_cmp #(.DW(DW)) u_cmp_hi (
    .val(shreg), .ref_addr(addr_r), .dont_care(mask_r), .use_lsb(1'b0), .hit(hit_hi)
  );

  i2c_addr_cmp #(.DW(DW)) u_cmp_full (
    .val(shreg), .ref_addr(addr_r), .dont_care(mask_r), .use_lsb(1'b1), .hit(hit_full)
  );

  assign host_rd_buf = reg_rd && (reg_addr == RA_RXDATA);
  assign bf_eff      = bf_r & ~host_rd_buf;
  assign is_free     = ~bf_eff & ~ov_r;

  always_comb begin
    take      = 1'b0;
    want_upd  = 1'b0;
    set_m10   = 1'b0;
    nxt_phase = phase;
    unique case (phase)
      PH_ADDR_HI: begin
        nxt_phase = PH_SKIP;
        if (!ten_r) begin
          take = hit_hi;
          if (hit_hi && !shreg[0]) nxt_phase = PH_DATA;
        end else if (hit_hi && shreg[DW-1 -: HDR_W] == TEN_HDR) begin
          if (!shreg[0]) begin
            take      = 1'b1;
            want_upd  = 1'b1;
            nxt_phase = PH_ADDR_LO;
          end else if (matched10) begin
            take = 1'b1;
          end
        end
      end
      PH_ADDR_LO: begin
        take      = hit_full;
        want_upd  = hit_full;
        set_m10   = hit_full;
        nxt_phase = hit_full ? PH_DATA : PH_SKIP;
      end
      PH_DATA: take = 1'b1;
      default: nxt_phase = phase;
    endcase
    if (take && !is_free && phase != PH_DATA) nxt_phase = PH_SKIP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_r    <= '0;
      mask_r    <= '0;
      rxbuf_r   <= '0;
      en_r      <= 1'b0;
      ten_r     <= 1'b0;
      se_r      <= 1'b0;
      bf_r      <= 1'b0;
      ov_r      <= 1'b0;
      upd_r     <= 1'b0;
      irq_r     <= 1'b0;
      rw_r      <= 1'b0;
      ack_r     <= 1'b0;
      ev_pend   <= 1'b0;
      upd_pend  <= 1'b0;
      matched10 <= 1'b0;
      phase     <= PH_IDLE;
    end else begin
      if (reg_wr) begin
        unique case (reg_addr)
          RA_ADDR: begin
            addr_r <= reg_wdata;
            upd_r  <= 1'b0;
          end
          RA_MASK: mask_r <= reg_wdata;
          RA_CTRL: begin
            en_r  <= reg_wdata[CT_EN];
            ten_r <= reg_wdata[CT_TEN];
            se_r  <= reg_wdata[CT_SE];
          end
          RA_STAT: begin
            if (reg_wdata[ST_OV])  ov_r  <= 1'b0;
            if (reg_wdata[ST_IRQ]) irq_r <= 1'b0;
          end
          default: ;
        endcase
      end
      if (host_rd_buf) bf_r <= 1'b0;

      if (!en_r) begin
        phase     <= PH_IDLE;
        ack_r     <= 1'b0;
        upd_r     <= 1'b0;
        ev_pend   <= 1'b0;
        upd_pend  <= 1'b0;
        matched10 <= 1'b0;
      end else if (stop_det) begin
        phase     <= PH_IDLE;
        ack_r     <= 1'b0;
        upd_r     <= 1'b0;
        ev_pend   <= 1'b0;
        upd_pend  <= 1'b0;
        matched10 <= 1'b0;
        if (se_r) irq_r <= 1'b1;
      end else if (start_det) begin
        phase    <= PH_ADDR_HI;
        ack_r    <= 1'b0;
        ev_pend  <= 1'b0;
        upd_pend <= 1'b0;
        if (se_r) irq_r <= 1'b1;
      end else begin
        if (byte_done) begin
          phase <= nxt_phase;
          if (take) begin
            ev_pend  <= 1'b1;
            upd_pend <= want_upd & is_free;
            if (phase != PH_DATA) rw_r <= shreg[0];
            if (is_free) begin
              ack_r   <= 1'b1;
              rxbuf_r <= shreg;
              bf_r    <= 1'b1;
              if (set_m10) matched10 <= 1'b1;
            end else if (bf_eff) begin
              ov_r <= 1'b1;
            end
          end
        end
        if (ack_end) begin
          ack_r    <= 1'b0;
          ev_pend  <= 1'b0;
          upd_pend <= 1'b0;
          if (ev_pend)  irq_r <= 1'b1;
          if (upd_pend) upd_r <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        RA_RXDATA: reg_rdata <= rxbuf_r;
        RA_ADDR:   reg_rdata <= addr_r;
        RA_MASK:   reg_rdata <= mask_r;
        RA_CTRL:   reg_rdata <= DW'({se_r, ten_r, en_r});
        RA_STAT:   reg_rdata <= DW'({rw_r, irq_r, upd_r, ov_r, bf_r});
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign scl_oe_o = upd_r;
  assign sda_oe_o = ack_r;
  assign irq_o    = irq_r;

  AST_ACK_WITH_BUF: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> bf_r);  // R2
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(ack_end || start_det || stop_det));  // R3
  AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
    ov_r && !(reg_wr && reg_addr == RA_STAT && reg_wdata[ST_OV]) |=> ov_r);  // R5
  AST_BF_CLR_BY_READ: assert property (@(posedge clk) disable iff (rst)
    $fell(bf_r) |-> $past(host_rd_buf));  // R5
  AST_HOLD_TEN_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe_o) |-> ten_r);  // R7
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det && en_r |=> !sda_oe_o && !scl_oe_o);  // R1
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_r |=> !sda_oe_o && !scl_oe_o);  // R11
endmodule

// File: tb/i2c_slave_rx_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_rx_tb_top;
  import i2c_slv_pkg::*;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic scl_line, sda_line;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_rx #(.DW(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .irq_o(irq),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit match7(input logic [7:0] b, input logic [7:0] a, input logic [7:0] m);
    return ((b[7:1] ^ a[7:1]) & ~m[7:1]) == 7'd0;
  endfunction

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_release();
    while (scl_oe) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; qw();
    wait_release();
    scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit rd_at_done,
                           output bit acked, output logic [7:0] rd_val);
    rd_val = '0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw();
      wait_release();
      scl_m = 1'b1; qw(); qw();
      scl_m = 1'b0;
      if (i == 0 && rd_at_done) begin
        @(negedge clk); @(negedge clk);
        reg_addr = RA_RXDATA; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        rd_val = reg_rdata;
        repeat (Q - 3) @(negedge clk);
      end else begin
        qw();
      end
    end
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    acked = (sda_line == 1'b0);
    qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd, dummy, ab, d, msk;
    bit ack, hit, active;
    bit m_bf, m_ov, m_irq;
    logic [7:0] m_buf;
    int nb;

    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    reg_read(RA_STAT, rd);
    chk("R1 reset status", rd, 0);
    chk("R1 reset outputs", {scl_oe, sda_oe, irq}, 0);

    reg_write(RA_ADDR, 8'hB4);
    reg_write(RA_CTRL, 8'h01);

    // R2 matching address, R4 suppression while buffer full
    bus_start();
    send_byte(8'hB4, 1'b0, ack, dummy);
    chk("R2 own address acked", ack, 1);
    reg_read(RA_STAT, rd);
    chk("R2 buffer full after address", rd[ST_BF], 1);
    chk("R3 irq after address", irq, 1);
    send_byte(8'h96, 1'b0, ack, dummy);
    chk("R4 no ack while buffer full", ack, 0);
    bus_stop();
    reg_read(RA_STAT, rd);
    chk("R4 overflow set", rd[ST_OV], 1);
    reg_read(RA_RXDATA, rd);
    chk("R4 buffer kept", rd, 8'hB4);
    reg_read(RA_STAT, rd);
    chk("R5 read clears buffer full", rd[ST_BF], 0);
    chk("R5 overflow survives read", rd[ST_OV], 1);
    bus_start();
    send_byte(8'hB4, 1'b0, ack, dummy);
    chk("R4 no ack while overflow", ack, 0);
    bus_stop();
    reg_read(RA_STAT, rd);
    chk("R4 buffer untouched under overflow", rd[ST_BF], 0);
    reg_write(RA_STAT, 8'h02);
    reg_read(RA_STAT, rd);
    chk("R5 overflow cleared by write", rd[ST_OV], 0);
    reg_write(RA_STAT, 8'h08);
    @(negedge clk);
    chk("R3 irq cleared by W1C", irq, 0);

    // R6 read coinciding with byte completion
    bus_start();
    send_byte(8'hB4, 1'b0, ack, dummy);
    send_byte(8'h3C, 1'b1, ack, rd);
    chk("R6 coincident read returns old byte", rd, 8'hB4);
    chk("R6 coincident byte acked", ack, 1);
    bus_stop();
    reg_read(RA_RXDATA, rd);
    chk("R6 new byte loaded", rd, 8'h3C);
    reg_read(RA_STAT, rd);
    chk("R6 no overflow", rd[ST_OV], 0);
    reg_write(RA_STAT, 8'h08);

    // R2 mismatch and mask
    bus_start();
    send_byte(8'hB6, 1'b0, ack, dummy);
    chk("R2 mismatch not acked", ack, 0);
    send_byte(8'h11, 1'b0, ack, dummy);
    chk("R2 data after mismatch ignored", ack, 0);
    bus_stop();
    reg_read(RA_STAT, rd);
    chk("R2 mismatch leaves flags", rd[3:0], 0);
    reg_write(RA_MASK, 8'h02);
    bus_start();
    send_byte(8'hB6, 1'b0, ack, dummy);
    chk("R2 masked bit ignored", ack, 1);
    bus_stop();
    reg_read(RA_RXDATA, rd);
    chk("R2 masked address loaded", rd, 8'hB6);
    reg_write(RA_MASK, 8'h00);
    reg_write(RA_STAT, 8'h0A);

    // R11 disabled
    reg_write(RA_CTRL, 8'h00);
    bus_start();
    send_byte(8'hB4, 1'b0, ack, dummy);
    chk("R11 disabled no ack", ack, 0);
    bus_stop();
    reg_read(RA_STAT, rd);
    chk("R11 disabled no flags", rd[3:0], 0);

    // R10 start/stop interrupts
    reg_write(RA_CTRL, 8'h05);
    bus_start();
    chk("R10 irq on start", irq, 1);
    reg_write(RA_STAT, 8'h08);
    @(negedge clk);
    bus_stop();
    chk("R10 irq on stop", irq, 1);
    reg_write(RA_STAT, 8'h08);
    reg_write(RA_CTRL, 8'h01);

    // Random 7-bit traffic against a bench model
    m_bf = 1'b0; m_ov = 1'b0; m_irq = 1'b0; m_buf = 8'hB6;
    for (int t = 0; t < 40; t++) begin
      msk = ($urandom % 2) ? 8'h06 : 8'h00;
      reg_write(RA_MASK, msk);
      if ($urandom % 2) ab = {7'h5A ^ {5'b0, 2'($urandom % 4)}, 1'b0};
      else ab = {7'($urandom), 1'b0};
      hit = match7(ab, 8'hB4, msk);
      active = hit && !m_bf && !m_ov;
      bus_start();
      send_byte(ab, 1'b0, ack, dummy);
      chk("R2 random address ack", ack, active);
      if (hit) begin
        m_irq = 1'b1;
        if (!m_bf && !m_ov) begin m_buf = ab; m_bf = 1'b1; end
        else if (m_bf) m_ov = 1'b1;
      end
      nb = 1 + ($urandom % 3);
      for (int k = 0; k < nb; k++) begin
        if ($urandom % 2) begin
          reg_read(RA_RXDATA, rd);
          chk("R5 random buffer read", rd, m_buf);
          m_bf = 1'b0;
        end
        d = 8'($urandom);
        send_byte(d, 1'b0, ack, dummy);
        chk("R4 random data ack", ack, active && !m_bf && !m_ov);
        if (active) begin
          m_irq = 1'b1;
          if (!m_bf && !m_ov) begin m_buf = d; m_bf = 1'b1; end
          else if (m_bf) m_ov = 1'b1;
        end
      end
      bus_stop();
      reg_read(RA_STAT, rd);
      chk("R4 random status", {rd[ST_IRQ], rd[ST_OV], rd[ST_BF]}, {m_irq, m_ov, m_bf});
      if ($urandom % 3 == 0) begin
        reg_write(RA_STAT, 8'h0A); m_ov = 1'b0;
      end else begin
        reg_write(RA_STAT, 8'h08);
      end
      m_irq = 1'b0;
    end
    reg_read(RA_RXDATA, rd);
    reg_write(RA_STAT, 8'h0A);
    reg_write(RA_MASK, 8'h00);

    // 10-bit addressing: address 0x2C7 -> header 0xF4, low byte 0xC7
    reg_write(RA_CTRL, 8'h03);
    reg_write(RA_ADDR, 8'hF4);
    bus_start();
    send_byte(8'hF4, 1'b0, ack, dummy);
    chk("R7 header acked", ack, 1);
    reg_read(RA_STAT, rd);
    chk("R7 flags after header", rd[3:0], 4'b1101);
    chk("R7 SCL held", scl_oe, 1);
    reg_read(RA_RXDATA, rd);
    chk("R7 header loaded", rd, 8'hF4);
    reg_write(RA_ADDR, 8'hC7);
    @(negedge clk);
    chk("R7 SCL released by address write", scl_oe, 0);
    reg_write(RA_STAT, 8'h08);
    send_byte(8'hC7, 1'b0, ack, dummy);
    chk("R8 low byte acked", ack, 1);
    reg_read(RA_STAT, rd);
    chk("R8 update flag after low byte", rd[ST_UPD], 1);
    chk("R8 SCL held", scl_oe, 1);
    reg_read(RA_RXDATA, rd);
    reg_write(RA_ADDR, 8'hF4);
    @(negedge clk);
    chk("R8 SCL released", scl_oe, 0);
    reg_write(RA_STAT, 8'h08);
    send_byte(8'h3E, 1'b0, ack, dummy);
    chk("R8 data acked", ack, 1);
    reg_read(RA_RXDATA, rd);
    chk("R8 data loaded", rd, 8'h3E);
    reg_write(RA_STAT, 8'h08);
    bus_rstart();
    send_byte(8'hF5, 1'b0, ack, dummy);
    chk("R9 read header acked", ack, 1);
    reg_read(RA_STAT, rd);
    chk("R9 flags bf irq no upd", rd[3:0], 4'b1001);
    chk("R9 SCL not held", scl_oe, 0);
    bus_stop();
    reg_read(RA_RXDATA, rd);
    reg_write(RA_STAT, 8'h08);
    bus_start();
    send_byte(8'hF5, 1'b0, ack, dummy);
    chk("R9 read header without match", ack, 0);
    bus_stop();
    reg_read(RA_STAT, rd);
    chk("R9 no flags without match", rd[3:0], 0);

    summary();
    $finish;
  end
endmodule